// File: doc/BRIEF.md
# Flash Command Sequence Decoder

This block sits on the write path of an embedded flash array. It watches every bus write cycle and recognises the multi-write unlock-and-command sequences that software uses to start flash operations. Each recognised sequence becomes one registered request: a one-cycle `cmdValid` pulse carrying an opcode, the captured address and data, and a mask of the blocks to erase. A write that does not fit the step the decoder expects ends the sequence quietly. The decoder then returns to idle and issues no request.

Program and erase sequences start with an unlock pair of writes at two fixed offsets. Protection sequences start with a different offset pair. A block erase stays open for further block addresses during an append window of `WINDOW_CYCLES` clock cycles. Each appended block restarts that window. The erase request goes out only when the window runs out with no further write. Erase suspend and resume are single writes and are accepted even while the array controller reports busy.

Top module: `flash_cmd_decoder`

## Requirements
- R1: While reset is applied and just after it, `cmdValid`, `windowOpen` and `eraseMask` are all zero.
- R2: Writing A8h at offset 1554h, then 54h at 2AA8h, then A0h at 1554h, then any write W gives `cmdValid` high on the cycle after W, with `cmdOp` = 1 (program) and `cmdAddr`/`cmdData` equal to the address and data of W.
- R3: Offsets are matched on address bits 13:0 only, and command codes on data bits 7:0 only. Higher address bits and the upper data byte have no effect on decoding.
- R4: Unlock, 80h at 1554h, unlock again, then 10h at 1554h issues `cmdOp` = 3 (chip erase) with every bit of `eraseMask` set.
- R5: Unlock, 80h at 1554h, unlock, then 30h at an address opens the append window (`windowOpen` high). Bit `addr[BLOCK_SHIFT +: log2(NUM_BLOCKS)]` of the mask is set. If no write follows, `cmdOp` = 2 (block erase) is issued together with the collected `eraseMask` on the cycle that lies exactly `WINDOW_CYCLES` cycles after the last accepted block write, and `windowOpen` falls at that same cycle.
- R6: While the window is open, each write of 30h adds its block to the mask and restarts the window. A write that lands `WINDOW_CYCLES` cycles after the previous block write is still accepted.
- R7: In idle, a single write of F0h at any address issues `cmdOp` = 4 (read/reset). F0h at 1554h after the unlock pair does the same.
- R8: In idle, a single write of B0h issues `cmdOp` = 5 (erase suspend) and a single write of 30h issues `cmdOp` = 6 (erase resume), whatever the level of `busy`.
- R9: After A8h at 2A54h, 54h at 15A8h and a third write at 2A54h: C0h followed by a write at an address with bits 1:0 = 10b issues `cmdOp` = 7 (set protection) with that address and data. 90h issues `cmdOp` = 8 (read protection). C1h followed by F0h issues `cmdOp` = 9 (temporary unprotect).
- R10: A write that does not match the expected step aborts the sequence with no request. This covers a wrong unlock write, a set-protection word at an address whose bits 1:0 are not 10b, and any non-30h write inside the append window. After the abort, the decoder is back in idle.
- R11: While `busy` is high, an unlock write in idle is ignored. A program or erase sequence written during that time issues no request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| wrEn | input | 1 | Write cycle strobe, one per write |
| wrAddr | input | ADDR_W (24) | Word address of the write |
| wrData | input | DATA_W (16) | Write data |
| busy | input | 1 | Array controller busy with program or erase |
| cmdValid | output | 1 | Request pulse |
| cmdOp | output | 4 | Request opcode (codes given in R2, R4, R5, R7, R8, R9) |
| cmdAddr | output | ADDR_W (24) | Address captured with the request |
| cmdData | output | DATA_W (16) | Data captured with the request |
| eraseMask | output | NUM_BLOCKS (8) | Blocks selected for erase |
| windowOpen | output | 1 | High while erase block appends are accepted |

## Verification
The bound checker checks the following on every cycle:
- a program request carries the address and data of the write before it;
- chip erase carries a full mask;
- block erase fires only after an open window with no write in the final cycle, and with a non-empty mask;
- the window opens only on a 30h write;
- a foreign write in the window closes it with no request;
- every request other than block erase follows a write.

Some behaviour depends on sequences of several writes, and only the bench's scenarios can show it. This covers the exact window length and the append boundary, the block index decode for every block, the different unlock pairs, the effect of `busy` on whole sequences, and a clean recovery after an abort.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [3:0] {
    OP_NONE        = 4'd0,
    OP_PROGRAM     = 4'd1,
    OP_BLOCK_ERASE = 4'd2,
    OP_CHIP_ERASE  = 4'd3,
    OP_RESET       = 4'd4,
    OP_SUSPEND     = 4'd5,
    OP_RESUME      = 4'd6,
    OP_SET_PROT    = 4'd7,
    OP_READ_PROT   = 4'd8,
    OP_UNPROTECT   = 4'd9
  } cmdOp_e;

  // offsets compared on bits 13:0
  localparam logic [13:0] OFS_MAIN_A = 14'h1554;
  localparam logic [13:0] OFS_MAIN_B = 14'h2AA8;
  localparam logic [13:0] OFS_PROT_A = 14'h2A54;
  localparam logic [13:0] OFS_PROT_B = 14'h15A8;

  localparam logic [7:0] CODE_KEY1     = 8'hA8;
  localparam logic [7:0] CODE_KEY2     = 8'h54;
  localparam logic [7:0] CODE_PROGRAM  = 8'hA0;
  localparam logic [7:0] CODE_ERASE    = 8'h80;
  localparam logic [7:0] CODE_BLOCK    = 8'h30;
  localparam logic [7:0] CODE_CHIP     = 8'h10;
  localparam logic [7:0] CODE_RESET    = 8'hF0;
  localparam logic [7:0] CODE_SUSPEND  = 8'hB0;
  localparam logic [7:0] CODE_SETPROT  = 8'hC0;
  localparam logic [7:0] CODE_READPROT = 8'h90;
  localparam logic [7:0] CODE_UNPROT   = 8'hC1;

  typedef struct packed {
    logic   issue;
    cmdOp_e op;
    logic   addBlock;
    logic   firstBlock;
    logic   loadTimer;
    logic   tickTimer;
  } ctrlStrobe_t;

endpackage

// File: rtl/fcd_ctrl.sv
module fcd_ctrl
  import fcd_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        wrEn,
  input  logic [13:0] wrOfs,
  input  logic [7:0]  wrCode,
  input  logic        busy,
  input  logic        timerLast,
  output ctrlStrobe_t strobe,
  output logic        windowOpen
);

  typedef enum logic [3:0] {
    S_IDLE, S_UNL1, S_UNL2, S_PROG, S_ERA1, S_ERA2, S_ERA3,
    S_EWIN, S_PUN1, S_PUN2, S_PSET, S_PTU
  } state_e;

  state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= S_IDLE;
    else       state <= nextState;
  end

  assign windowOpen = (state == S_EWIN);

  always_comb begin
    nextState = state;
    strobe    = '0;
    strobe.op = OP_NONE;
    unique case (state)
      S_IDLE: if (wrEn) begin
        if (wrCode == CODE_RESET) begin
          strobe.issue = 1'b1; strobe.op = OP_RESET;
        end else if (wrCode == CODE_SUSPEND) begin
          strobe.issue = 1'b1; strobe.op = OP_SUSPEND;
        end else if (wrCode == CODE_BLOCK) begin
          strobe.issue = 1'b1; strobe.op = OP_RESUME;
        end else if (wrCode == CODE_KEY1 && !busy) begin
          if (wrOfs == OFS_MAIN_A)      nextState = S_UNL1;
          else if (wrOfs == OFS_PROT_A) nextState = S_PUN1;
        end
      end
      S_UNL1: if (wrEn)
        nextState = (wrCode == CODE_KEY2 && wrOfs == OFS_MAIN_B) ? S_UNL2 : S_IDLE;
      S_UNL2: if (wrEn) begin
        nextState = S_IDLE;
        if (wrOfs == OFS_MAIN_A) begin
          if (wrCode == CODE_PROGRAM)    nextState = S_PROG;
          else if (wrCode == CODE_ERASE) nextState = S_ERA1;
          else if (wrCode == CODE_RESET) begin
            strobe.issue = 1'b1; strobe.op = OP_RESET;
          end
        end
      end
      S_PROG: if (wrEn) begin
        nextState = S_IDLE;
        strobe.issue = 1'b1; strobe.op = OP_PROGRAM;
      end
      S_ERA1: if (wrEn)
        nextState = (wrCode == CODE_KEY1 && wrOfs == OFS_MAIN_A) ? S_ERA2 : S_IDLE;
      S_ERA2: if (wrEn)
        nextState = (wrCode == CODE_KEY2 && wrOfs == OFS_MAIN_B) ? S_ERA3 : S_IDLE;
      S_ERA3: if (wrEn) begin
        nextState = S_IDLE;
        if (wrCode == CODE_BLOCK) begin
          nextState         = S_EWIN;
          strobe.addBlock   = 1'b1;
          strobe.firstBlock = 1'b1;
          strobe.loadTimer  = 1'b1;
        end else if (wrCode == CODE_CHIP && wrOfs == OFS_MAIN_A) begin
          strobe.issue = 1'b1; strobe.op = OP_CHIP_ERASE;
        end
      end
      S_EWIN: begin
        if (wrEn) begin
          if (wrCode == CODE_BLOCK) begin
            strobe.addBlock  = 1'b1;
            strobe.loadTimer = 1'b1;
          end else begin
            nextState = S_IDLE;
          end
        end else if (timerLast) begin
          nextState = S_IDLE;
          strobe.issue = 1'b1; strobe.op = OP_BLOCK_ERASE;
        end else begin
          strobe.tickTimer = 1'b1;
        end
      end
      S_PUN1: if (wrEn)
        nextState = (wrCode == CODE_KEY2 && wrOfs == OFS_PROT_B) ? S_PUN2 : S_IDLE;
      S_PUN2: if (wrEn) begin
        nextState = S_IDLE;
        if (wrOfs == OFS_PROT_A) begin
          if (wrCode == CODE_SETPROT)      nextState = S_PSET;
          else if (wrCode == CODE_UNPROT)  nextState = S_PTU;
          else if (wrCode == CODE_READPROT) begin
            strobe.issue = 1'b1; strobe.op = OP_READ_PROT;
          end
        end
      end
      S_PSET: if (wrEn) begin
        nextState = S_IDLE;
        if (wrOfs[1:0] == 2'b10) begin
          strobe.issue = 1'b1; strobe.op = OP_SET_PROT;
        end
      end
      S_PTU: if (wrEn) begin
        nextState = S_IDLE;
        if (wrCode == CODE_RESET) begin
          strobe.issue = 1'b1; strobe.op = OP_UNPROTECT;
        end
      end
      default: nextState = S_IDLE;
    endcase
  end

endmodule

// File: rtl/fcd_datapath.sv
module fcd_datapath
  import fcd_pkg::*;
#(
  parameter int ADDR_W        = 24,
  parameter int DATA_W        = 16,
  parameter int NUM_BLOCKS    = 8,
  parameter int BLOCK_SHIFT   = 15,
  parameter int WINDOW_CYCLES = 4800
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  ctrlStrobe_t           strobe,
  output logic                  timerLast,
  output logic                  cmdValid,
  output logic [3:0]            cmdOp,
  output logic [ADDR_W-1:0]     cmdAddr,
  output logic [DATA_W-1:0]     cmdData,
  output logic [NUM_BLOCKS-1:0] eraseMask
);

  localparam int IDX_W = (NUM_BLOCKS > 1) ? $clog2(NUM_BLOCKS) : 1;
  localparam int CNT_W = $clog2(WINDOW_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(WINDOW_CYCLES);

  logic [IDX_W-1:0]      blkIdx;
  logic [NUM_BLOCKS-1:0] blkHit;
  logic [NUM_BLOCKS-1:0] accMask;
  logic [CNT_W-1:0]      winCnt;

  assign blkIdx = wrAddr[BLOCK_SHIFT +: IDX_W];

  for (genvar g = 0; g < NUM_BLOCKS; g++) begin : g_hit
    assign blkHit[g] = (blkIdx == IDX_W'(g));
  end

  assign timerLast = (winCnt == CNT_W'(1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      winCnt  <= '0;
      accMask <= '0;
    end else begin
      if (strobe.loadTimer)      winCnt <= CNT_LOAD;
      else if (strobe.tickTimer) winCnt <= winCnt - CNT_W'(1);
      if (strobe.addBlock)
        accMask <= (strobe.firstBlock ? '0 : accMask) | blkHit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdValid  <= 1'b0;
      cmdOp     <= 4'(OP_NONE);
      cmdAddr   <= '0;
      cmdData   <= '0;
      eraseMask <= '0;
    end else begin
      cmdValid <= strobe.issue;
      if (strobe.issue) begin
        cmdOp   <= 4'(strobe.op);
        cmdAddr <= wrAddr;
        cmdData <= wrData;
        if (strobe.op == OP_BLOCK_ERASE)     eraseMask <= accMask;
        else if (strobe.op == OP_CHIP_ERASE) eraseMask <= '1;
        else                                 eraseMask <= '0;
      end
    end
  end

endmodule

// File: rtl/flash_cmd_decoder.sv
module flash_cmd_decoder
  import fcd_pkg::*;
#(
  parameter int ADDR_W        = 24,
  parameter int DATA_W        = 16,
  parameter int NUM_BLOCKS    = 8,
  parameter int BLOCK_SHIFT   = 15,
  parameter int WINDOW_CYCLES = 4800
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  wrEn,
  input  logic [ADDR_W-1:0]     wrAddr,
  input  logic [DATA_W-1:0]     wrData,
  input  logic                  busy,
  output logic                  cmdValid,
  output logic [3:0]            cmdOp,
  output logic [ADDR_W-1:0]     cmdAddr,
  output logic [DATA_W-1:0]     cmdData,
  output logic [NUM_BLOCKS-1:0] eraseMask,
  output logic                  windowOpen
);

  ctrlStrobe_t strobe;
  logic        timerLast;

  fcd_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .wrEn       (wrEn),
    .wrOfs      (wrAddr[13:0]),
    .wrCode     (wrData[7:0]),
    .busy       (busy),
    .timerLast  (timerLast),
    .strobe     (strobe),
    .windowOpen (windowOpen)
  );

  fcd_datapath #(
    .ADDR_W        (ADDR_W),
    .DATA_W        (DATA_W),
    .NUM_BLOCKS    (NUM_BLOCKS),
    .BLOCK_SHIFT   (BLOCK_SHIFT),
    .WINDOW_CYCLES (WINDOW_CYCLES)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .wrAddr    (wrAddr),
    .wrData    (wrData),
    .strobe    (strobe),
    .timerLast (timerLast),
    .cmdValid  (cmdValid),
    .cmdOp     (cmdOp),
    .cmdAddr   (cmdAddr),
    .cmdData   (cmdData),
    .eraseMask (eraseMask)
  );

endmodule

// File: rtl/fcd_checker.sv
module fcd_checker #(
  parameter int ADDR_W     = 24,
  parameter int DATA_W     = 16,
  parameter int NUM_BLOCKS = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  wrEn,
  input logic [ADDR_W-1:0]     wrAddr,
  input logic [DATA_W-1:0]     wrData,
  input logic                  busy,
  input logic                  cmdValid,
  input logic [3:0]            cmdOp,
  input logic [ADDR_W-1:0]     cmdAddr,
  input logic [DATA_W-1:0]     cmdData,
  input logic [NUM_BLOCKS-1:0] eraseMask,
  input logic                  windowOpen
);

  // R2
  program_capture_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 4'd1) |-> (cmdAddr == $past(wrAddr) && cmdData == $past(wrData)));

  // R4
  chip_mask_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 4'd3) |-> (&eraseMask));

  // R5
  block_after_quiet_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp == 4'd2) |-> ($past(windowOpen) && !$past(wrEn) && eraseMask != '0));

  // R5
  window_opens_on_block_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(windowOpen) |-> ($past(wrEn) && $past(wrData[7:0]) == 8'h30));

  // R10
  window_abort_chk: assert property (@(posedge clk) disable iff (!rstN)
    (windowOpen && wrEn && wrData[7:0] != 8'h30) |=> (!windowOpen && !cmdValid));

  // R7
  request_follows_write_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOp != 4'd2) |-> $past(wrEn));

  // R11
  busy_idle_no_window_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!windowOpen && busy && wrEn) |=> !windowOpen);

endmodule

bind flash_cmd_decoder fcd_checker #(
  .ADDR_W     (ADDR_W),
  .DATA_W     (DATA_W),
  .NUM_BLOCKS (NUM_BLOCKS)
) u_chk (
  .clk        (clk),
  .rstN       (rstN),
  .wrEn       (wrEn),
  .wrAddr     (wrAddr),
  .wrData     (wrData),
  .busy       (busy),
  .cmdValid   (cmdValid),
  .cmdOp      (cmdOp),
  .cmdAddr    (cmdAddr),
  .cmdData    (cmdData),
  .eraseMask  (eraseMask),
  .windowOpen (windowOpen)
);

// File: tb/flash_cmd_decoder_bench.sv
`timescale 1ns/1ps
module flash_cmd_decoder_bench;

  localparam int AW = 24;
  localparam int DW = 16;
  localparam int NB = 8;
  localparam int BS = 15;
  localparam int WC = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [DW-1:0] wrData = '0;
  logic          busy = 1'b0;
  logic          cmdValid;
  logic [3:0]    cmdOp;
  logic [AW-1:0] cmdAddr;
  logic [DW-1:0] cmdData;
  logic [NB-1:0] eraseMask;
  logic          windowOpen;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  logic          sV, sWin;
  logic [3:0]    sOp;
  logic [AW-1:0] sAddr;
  logic [DW-1:0] sData;
  logic [NB-1:0] sMask;

  always #10 clk = ~clk;

  flash_cmd_decoder #(
    .ADDR_W(AW), .DATA_W(DW), .NUM_BLOCKS(NB), .BLOCK_SHIFT(BS), .WINDOW_CYCLES(WC)
  ) u_flash_cmd_decoder (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData), .busy(busy),
    .cmdValid(cmdValid), .cmdOp(cmdOp), .cmdAddr(cmdAddr), .cmdData(cmdData),
    .eraseMask(eraseMask), .windowOpen(windowOpen)
  );

  task automatic snap();
    sV = cmdValid; sWin = windowOpen; sOp = cmdOp;
    sAddr = cmdAddr; sData = cmdData; sMask = eraseMask;
  endtask

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // one write cycle; returns at the next falling edge with outputs captured
  task automatic wr(input logic [AW-1:0] a, input logic [DW-1:0] d);
    wrEn = 1'b1; wrAddr = a; wrData = d;
    @(negedge clk);
    snap();
    wrEn = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      snap();
    end
  endtask

  function automatic logic [AW-1:0] ofs(input logic [9:0] hi, input logic [13:0] o);
    return {hi, o};
  endfunction

  task automatic unlockMain(input logic [9:0] hi, input logic [7:0] junk);
    wr(ofs(hi, 14'h1554), {junk, 8'hA8});
    wr(ofs(hi, 14'h2AA8), {junk, 8'h54});
  endtask

  task automatic unlockProt();
    wr(ofs(10'h3, 14'h2A54), 16'h00A8);
    wr(ofs(10'h1, 14'h15A8), 16'h0054);
  endtask

  task automatic eraseHead();
    unlockMain(10'h0, 8'h00);
    wr(ofs(10'h0, 14'h1554), 16'h0080);
    unlockMain(10'h2, 8'h77);
  endtask

  function automatic logic [AW-1:0] blkAddr(input int b);
    return AW'(b) << BS | AW'(24'h0123);
  endfunction

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    snap();
    // R1 during reset
    chk(!sV && !sWin && sMask == '0, "R1", "reset outputs", {sV, sWin, sMask}, 0);
    rstN = 1'b1;
    @(negedge clk);
    snap();
    chk(!sV && !sWin && sMask == '0, "R1", "after reset", {sV, sWin, sMask}, 0);

    // R2 / R3: program sweep with varied upper address bits and upper data byte
    for (int i = 0; i < 8; i++) begin
      logic [AW-1:0] a;
      logic [DW-1:0] d;
      a = AW'(i * 24'h01_2345 + 2);
      d = DW'(i * 16'h1357 + 16'h0102);
      unlockMain(10'(i * 37), 8'(i * 29 + 1));
      chk(!sV, "R3", "no request after unlock", sV, 0);
      wr(ofs(10'(i * 11), 14'h1554), {8'(i), 8'hA0});
      chk(!sV, "R2", "no request after A0", sV, 0);
      wr(a, d);
      chk(sV && sOp == 4'd1, "R2", "program op", {sV, sOp}, {1'b1, 4'd1});
      chk(sAddr == a && sData == d, "R2", "program addr/data", {sAddr[15:0], sData}, {a[15:0], d});
      wr(ofs(0, 14'h0000), 16'h1200);
      chk(!sV, "R2", "single pulse", sV, 0);
    end

    // R4 chip erase
    eraseHead();
    wr(ofs(10'h3FF, 14'h1554), 16'hEE10);
    chk(sV && sOp == 4'd3 && sMask == 8'hFF, "R4", "chip erase", {sV, sOp, sMask}, {1'b1, 4'd3, 8'hFF});
    chk(!sWin, "R4", "no window", sWin, 0);

    // R5 each block alone, exact window length
    for (int b = 0; b < NB; b++) begin
      eraseHead();
      wr(blkAddr(b), 16'h0030);
      chk(sWin && !sV, "R5", "window open", {sWin, sV}, 2'b10);
      idle(WC - 1);
      chk(sWin && !sV, "R5", "window still open", {sWin, sV}, 2'b10);
      idle(1);
      chk(sV && sOp == 4'd2 && !sWin, "R5", "block erase issued", {sV, sOp, sWin}, {1'b1, 4'd2, 1'b0});
      chk(sMask == NB'(1 << b), "R5", "block mask", sMask, 1 << b);
    end

    // R6 appends, including the boundary cycle
    eraseHead();
    wr(blkAddr(1), 16'h0030);
    idle(WC - 1);
    wr(blkAddr(5), 16'hAB30);
    chk(sWin && !sV, "R6", "append at window edge", {sWin, sV}, 2'b10);
    idle(WC - 1);
    wr(blkAddr(6), 16'h0030);
    chk(sWin && !sV, "R6", "second append", {sWin, sV}, 2'b10);
    idle(WC);
    chk(sV && sOp == 4'd2 && sMask == 8'h62, "R6", "merged mask", {sV, sOp, sMask}, {1'b1, 4'd2, 8'h62});

    // R7 read/reset, both forms
    wr(24'h7A_BCDE, 16'h33F0);
    chk(sV && sOp == 4'd4, "R7", "single reset", {sV, sOp}, {1'b1, 4'd4});
    unlockMain(10'h5, 8'h00);
    wr(ofs(10'h9, 14'h1554), 16'h00F0);
    chk(sV && sOp == 4'd4, "R7", "unlocked reset", {sV, sOp}, {1'b1, 4'd4});

    // R8 suspend / resume under busy
    busy = 1'b1;
    wr(24'h12_3456, 16'h00B0);
    chk(sV && sOp == 4'd5, "R8", "suspend", {sV, sOp}, {1'b1, 4'd5});
    wr(24'h00_0010, 16'h0030);
    chk(sV && sOp == 4'd6, "R8", "resume", {sV, sOp}, {1'b1, 4'd6});

    // R11 busy blocks sequences
    unlockMain(10'h0, 8'h00);
    wr(ofs(10'h0, 14'h1554), 16'h00A0);
    wr(24'h00_4444, 16'h1234);
    chk(!sV, "R11", "program ignored while busy", sV, 0);
    eraseHead();
    wr(blkAddr(2), 16'h0010);
    chk(!sV && !sWin, "R11", "erase ignored while busy", {sV, sWin}, 0);
    busy = 1'b0;

    // R9 protection commands
    unlockProt();
    wr(ofs(10'h0, 14'h2A54), 16'h00C0);
    wr(24'h00_0006, 16'hABCD);
    chk(sV && sOp == 4'd7 && sAddr == 24'h6 && sData == 16'hABCD, "R9", "set protection",
        {sV, sOp, sData}, {1'b1, 4'd7, 16'hABCD});
    unlockProt();
    wr(ofs(10'h2, 14'h2A54), 16'h0090);
    chk(sV && sOp == 4'd8, "R9", "read protection", {sV, sOp}, {1'b1, 4'd8});
    unlockProt();
    wr(ofs(10'h0, 14'h2A54), 16'h00C1);
    chk(!sV, "R9", "no request before F0", sV, 0);
    wr(24'h00_0100, 16'h00F0);
    chk(sV && sOp == 4'd9, "R9", "temporary unprotect", {sV, sOp}, {1'b1, 4'd9});

    // R10 aborts
    unlockProt();
    wr(ofs(10'h0, 14'h2A54), 16'h00C0);
    wr(24'h00_0004, 16'h5555);
    chk(!sV, "R10", "even protection address", sV, 0);
    wr(ofs(10'h0, 14'h1554), 16'h00A8);
    wr(ofs(10'h0, 14'h2AA8), 16'h0055);
    chk(!sV, "R10", "wrong second key", sV, 0);
    wr(ofs(10'h0, 14'h1554), 16'h00A0);
    wr(24'h00_2222, 16'h1234);
    chk(!sV, "R10", "sequence discarded", sV, 0);
    eraseHead();
    wr(blkAddr(3), 16'h0030);
    wr(blkAddr(4), 16'h0031);
    chk(!sV && !sWin, "R10", "foreign write in window", {sV, sWin}, 0);
    idle(WC + 2);
    chk(!sV, "R10", "no late erase", sV, 0);
    unlockMain(10'h0, 8'h00);
    wr(ofs(10'h0, 14'h1554), 16'h00A0);
    wr(24'h00_3333, 16'h4321);
    chk(sV && sOp == 4'd1 && sData == 16'h4321, "R10", "recovery after abort",
        {sV, sOp, sData}, {1'b1, 4'd1, 16'h4321});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule